// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block is the controller-side engine that brings a DDR2 memory from power-on to a usable state. Once reset is released it keeps the clock-enable low for a programmable settling period, raises it, and then plays a fixed list of bank-precharge, mode-register and refresh commands. Each command is followed by the idle gap the memory needs before the next one. After the last gap it raises a completion flag and leaves the command bus at no-operation for good.

All delays are parameters counted in controller clock cycles. The four mode-register images are parameters as well. The sequencer forces the bits that the initialization flow owns: the DLL-reset bit of the main mode register, and the DLL-enable and drive-calibration bits of the first extended register. It does not carry out an impedance calibration routine, and it does not handle normal read or write traffic.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted (synchronous, active low), the outputs are: cke=0, odt=0, the bus holds NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), ba=0, addr=0 and init_done=0.
- R2: cke goes high on the STABLE_CYC-th clock edge after reset is released. Before that edge, only NOP is driven.
- R3: The first command is precharge-all ({cs_n,ras_n,cas_n,we_n}=4'b0010, addr bit 10 = 1, all other addr bits and ba = 0). It is issued exactly CKE_WAIT_CYC cycles after cke rises.
- R4: The commands follow this order:
  - precharge-all
  - extended register 2 write (ba=2)
  - extended register 3 write (ba=3)
  - extended register 1 write (ba=1)
  - main register write with addr bit 8 = 1 (ba=0)
  - precharge-all
  - NUM_REF refreshes (4'b0001, ba=0, addr=0)
  - main register write with addr bit 8 = 0
  - extended register 1 write with addr bits 9:7 = 3'b111
  - extended register 1 write with addr bits 9:7 = 3'b000

  Every register write is encoded 4'b0000.
- R5: A register write is followed by exactly TMRD_CYC cycles before the next command. A precharge-all is followed by TRP_CYC cycles, and a refresh by TRFC_CYC cycles.
- R6: The calibration-default write (bits 9:7 = 111) is issued at the later of two points: the end of the normal gap, or DLL_WAIT_CYC cycles after the DLL-reset write.
- R7: The main register data is MR_BASE with bit 8 overridden. The extended register 1 data is EMR1_BASE with bit 0 cleared and bits 9:7 overridden. Extended registers 2 and 3 carry EMR2_VAL and EMR3_VAL unchanged.
- R8: On every cycle without a command, the bus shows NOP with ba=0 and addr=0. odt stays low at all times.
- R9: init_done rises exactly TMRD_CYC cycles after the last write. It then stays high, with the bus at NOP.
- R10: Once cke is high, it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| odt | output | 1 | Termination enable, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank / register select |
| addr | output | ROW_W | Address / register data |
| init_done | output | 1 | Initialization complete |

## Verification
The bench runs two configurations side by side against a behavioural schedule, compared on every clock.

The first configuration has the production defaults. There the DLL lock window is longer than the refresh phase, so it decides when the calibration write goes out.

The second configuration has short delays, three refreshes and a short DLL window, so the normal gap decides instead. Its register images also have the forced bits set the wrong way, which exposes any failure to override them. Together the two runs separate the two sides of the timing maximum in R6 and show both loop lengths of the refresh phase.

// File: rtl/ddr2_init_pkg.sv
// Shared types for the DDR2 initialization sequencer.
// Assumes the phase order below is the issue order; the top module steps
// through it by incrementing.
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        PH_STABLE,
        PH_PALL_A,
        PH_EMR2,
        PH_EMR3,
        PH_EMR1_DLL,
        PH_MR_DLLRST,
        PH_PALL_B,
        PH_REFRESH,
        PH_MR_RUN,
        PH_OCD_DFLT,
        PH_OCD_EXIT,
        PH_TAIL,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    typedef enum logic [1:0] {
        GAP_MRD,
        GAP_RP,
        GAP_RFC
    } gap_kind_t;

    localparam pin_cmd_t CMD_NOP  = '{1'b0, 1'b1, 1'b1, 1'b1};
    localparam pin_cmd_t CMD_PALL = '{1'b0, 1'b0, 1'b1, 1'b0};
    localparam pin_cmd_t CMD_REF  = '{1'b0, 1'b0, 1'b0, 1'b1};
    localparam pin_cmd_t CMD_MRS  = '{1'b0, 1'b0, 1'b0, 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_init_gap_timer.sv
// Down-counter for command gaps.
// The counter is loaded with (gap - 1) and then decrements to zero, where it
// holds. The owner issues its next action on the first edge at which zero is
// seen. Assumes the owner loads it only while it is idle at zero.
module ddr2_init_gap_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Counter: load, or count down toward zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= W'(RST_VAL);
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // A running window is never restarted by its owner (R5).
    assert_load_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);

endmodule

// File: rtl/ddr2_init_step_rom.sv
// Per-phase command table.
// Maps a sequencer phase to its pin command, bank, address and following-gap
// class. The register images are the parameters, with the bits owned by the
// initialization flow forced here. Purely combinational; assumes ROW_W >= 11.
module ddr2_init_step_rom
    import ddr2_init_pkg::*;
#(
    parameter int               ROW_W     = 14,
    parameter int               BA_W      = 3,
    parameter logic [ROW_W-1:0] MR_BASE   = '0,
    parameter logic [ROW_W-1:0] EMR1_BASE = '0,
    parameter logic [ROW_W-1:0] EMR2_VAL  = '0,
    parameter logic [ROW_W-1:0] EMR3_VAL  = '0
) (
    input  phase_t           phase,
    output pin_cmd_t         cmd,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr,
    output gap_kind_t        gap
);

    localparam logic [ROW_W-1:0] BIT_AP      = ROW_W'(1) << 10;
    localparam logic [ROW_W-1:0] BIT_DLLRST  = ROW_W'(1) << 8;
    localparam logic [ROW_W-1:0] FIELD_OCD   = ROW_W'(7) << 7;
    localparam logic [ROW_W-1:0] BIT_DLLOFF  = ROW_W'(1);
    localparam logic [ROW_W-1:0] EMR1_NORMAL = EMR1_BASE & ~(FIELD_OCD | BIT_DLLOFF);

    // Table lookup for the current phase.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        gap  = GAP_MRD;
        case (phase)
            PH_PALL_A, PH_PALL_B: begin
                cmd = CMD_PALL; addr = BIT_AP; gap = GAP_RP;
            end
            PH_EMR2:      begin cmd = CMD_MRS; ba = BA_W'(2); addr = EMR2_VAL; end
            PH_EMR3:      begin cmd = CMD_MRS; ba = BA_W'(3); addr = EMR3_VAL; end
            PH_EMR1_DLL:  begin cmd = CMD_MRS; ba = BA_W'(1); addr = EMR1_NORMAL; end
            PH_MR_DLLRST: begin cmd = CMD_MRS; addr = MR_BASE | BIT_DLLRST; end
            PH_REFRESH:   begin cmd = CMD_REF; gap = GAP_RFC; end
            PH_MR_RUN:    begin cmd = CMD_MRS; addr = MR_BASE & ~BIT_DLLRST; end
            PH_OCD_DFLT:  begin cmd = CMD_MRS; ba = BA_W'(1); addr = EMR1_NORMAL | FIELD_OCD; end
            PH_OCD_EXIT:  begin cmd = CMD_MRS; ba = BA_W'(1); addr = EMR1_NORMAL; end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer (top).
// Waits STABLE_CYC cycles with cke low and then raises cke. After a further
// CKE_WAIT_CYC cycles it plays the fixed command list, respecting the tMRD,
// tRP and tRFC gaps and a DLL lock window, then raises init_done.
// Assumes every delay parameter is >= 1 and TMRD_CYC >= 2.
// All outputs are registered.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int               ROW_W        = 14,
    parameter int               BA_W         = 3,
    parameter int               STABLE_CYC   = 40000,
    parameter int               CKE_WAIT_CYC = 80,
    parameter int               TMRD_CYC     = 2,
    parameter int               TRP_CYC      = 3,
    parameter int               TRFC_CYC     = 26,
    parameter int               NUM_REF      = 2,
    parameter int               DLL_WAIT_CYC = 200,
    parameter logic [ROW_W-1:0] MR_BASE      = 14'h0A62,
    parameter logic [ROW_W-1:0] EMR1_BASE    = 14'h0004,
    parameter logic [ROW_W-1:0] EMR2_VAL     = 14'h0000,
    parameter logic [ROW_W-1:0] EMR3_VAL     = 14'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             cke,
    output logic             odt,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr,
    output logic             init_done
);

    localparam int MAX_GAP = imax(imax(STABLE_CYC, CKE_WAIT_CYC),
                                  imax(TRFC_CYC, imax(TMRD_CYC, TRP_CYC)));
    localparam int GAP_W = $clog2(MAX_GAP + 1);
    localparam int DLL_W = $clog2(DLL_WAIT_CYC + 1);
    localparam int REF_W = $clog2(NUM_REF + 1);

    phase_t           phase_q, phase_d;
    logic [REF_W-1:0] ref_q;
    logic             cke_q, done_q;
    pin_cmd_t         cmd_q;
    logic [BA_W-1:0]  ba_q;
    logic [ROW_W-1:0] addr_q;

    pin_cmd_t         step_cmd;
    logic [BA_W-1:0]  step_ba;
    logic [ROW_W-1:0] step_addr;
    gap_kind_t        step_gap;

    logic             gap_zero, dll_zero, gap_load, dll_load, issue, cmd_phase;
    logic [GAP_W-1:0] gap_val;

    ddr2_init_step_rom #(
        .ROW_W(ROW_W), .BA_W(BA_W), .MR_BASE(MR_BASE), .EMR1_BASE(EMR1_BASE),
        .EMR2_VAL(EMR2_VAL), .EMR3_VAL(EMR3_VAL)
    ) i_rom (
        .phase(phase_q), .cmd(step_cmd), .ba(step_ba), .addr(step_addr), .gap(step_gap)
    );

    ddr2_init_gap_timer #(.W(GAP_W), .RST_VAL(STABLE_CYC - 1)) i_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
    );

    ddr2_init_gap_timer #(.W(DLL_W), .RST_VAL(0)) i_dll (
        .clk(clk), .rst_n(rst_n), .load(dll_load),
        .load_val(DLL_W'(DLL_WAIT_CYC - 1)), .zero(dll_zero)
    );

    // Issue decision: a command phase whose gap and (if relevant) DLL window are over.
    always_comb begin
        cmd_phase = (phase_q >= PH_PALL_A) && (phase_q <= PH_OCD_EXIT);
        issue     = cmd_phase && gap_zero && ((phase_q != PH_OCD_DFLT) || dll_zero);
        gap_load  = issue || ((phase_q == PH_STABLE) && gap_zero);
        dll_load  = issue && (phase_q == PH_MR_DLLRST);
    end

    // Gap length that follows the current action.
    always_comb begin
        if (phase_q == PH_STABLE) gap_val = GAP_W'(CKE_WAIT_CYC - 1);
        else begin
            case (step_gap)
                GAP_RP:  gap_val = GAP_W'(TRP_CYC - 1);
                GAP_RFC: gap_val = GAP_W'(TRFC_CYC - 1);
                default: gap_val = GAP_W'(TMRD_CYC - 1);
            endcase
        end
    end

    // Next-phase selection, including the refresh repeat loop.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_STABLE:  if (gap_zero) phase_d = PH_PALL_A;
            PH_TAIL:    if (gap_zero) phase_d = PH_DONE;
            PH_REFRESH: if (issue && (ref_q == REF_W'(NUM_REF - 1))) phase_d = PH_MR_RUN;
            PH_DONE:    phase_d = PH_DONE;
            default:    if (issue) phase_d = phase_t'(phase_q + 4'd1);
        endcase
    end

    // State and registered pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STABLE;
            ref_q   <= '0;
            cke_q   <= 1'b0;
            done_q  <= 1'b0;
            cmd_q   <= CMD_NOP;
            ba_q    <= '0;
            addr_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if ((phase_q == PH_STABLE) && gap_zero) cke_q <= 1'b1;
            if ((phase_q == PH_TAIL) && gap_zero) done_q <= 1'b1;
            if (issue && (phase_q == PH_REFRESH)) ref_q <= ref_q + 1'b1;
            cmd_q  <= issue ? step_cmd  : CMD_NOP;
            ba_q   <= issue ? step_ba   : '0;
            addr_q <= issue ? step_addr : '0;
        end
    end

    assign cke       = cke_q;
    assign odt       = 1'b0;
    assign cs_n      = cmd_q.cs_n;
    assign ras_n     = cmd_q.ras_n;
    assign cas_n     = cmd_q.cas_n;
    assign we_n      = cmd_q.we_n;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign init_done = done_q;

    assert_nop_while_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |-> (cmd_q == CMD_NOP));

    assert_cke_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cke_q |=> cke_q);

    assert_refresh_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_MR_RUN) && ($past(phase_q) == PH_REFRESH)) |-> (ref_q == REF_W'(NUM_REF)));

    assert_mrd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);

    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((cmd_q == CMD_NOP) && (addr_q == '0)));

endmodule

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
// Bench: two configurations compared every cycle against a schedule that is
// computed behaviourally from the requirements.
module test_ddr2_init_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cke0, odt0, cs0, ras0, cas0, we0, done0;
    logic [2:0]  ba0;
    logic [13:0] addr0;
    logic        cke1, odt1, cs1, ras1, cas1, we1, done1;
    logic [2:0]  ba1;
    logic [13:0] addr1;

    ddr2_init_seq i_ddr2_init_seq (
        .clk(clk), .rst_n(rst_n), .cke(cke0), .odt(odt0), .cs_n(cs0), .ras_n(ras0),
        .cas_n(cas0), .we_n(we0), .ba(ba0), .addr(addr0), .init_done(done0)
    );

    ddr2_init_seq #(
        .STABLE_CYC(50), .CKE_WAIT_CYC(10), .TMRD_CYC(3), .TRP_CYC(4), .TRFC_CYC(30),
        .NUM_REF(3), .DLL_WAIT_CYC(40), .MR_BASE(14'h0D53), .EMR1_BASE(14'h0387),
        .EMR2_VAL(14'h0080), .EMR3_VAL(14'h0001)
    ) i_ddr2_init_seq_alt (
        .clk(clk), .rst_n(rst_n), .cke(cke1), .odt(odt1), .cs_n(cs1), .ras_n(ras1),
        .cas_n(cas1), .we_n(we1), .ba(ba1), .addr(addr1), .init_done(done1)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Expected schedule per instance.
    int          ev_t   [2][32];
    logic [3:0]  ev_pins[2][32];
    logic [2:0]  ev_ba  [2][32];
    logic [13:0] ev_addr[2][32];
    int          ev_tag [2][32];
    int          ev_n   [2];
    int          ev_ptr [2];
    int          t_cke  [2];
    int          t_done [2];

    task automatic check(input bit ok, input int tag, input int k, input int cyc,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d inst %0d cycle %0d: actual %h expected %h", tag, k, cyc, act, exp);
        end
    endtask

    task automatic push(input int k, input int t, input logic [3:0] pins,
                        input logic [2:0] b, input logic [13:0] a, input int tag);
        ev_t[k][ev_n[k]]    = t;
        ev_pins[k][ev_n[k]] = pins;
        ev_ba[k][ev_n[k]]   = b;
        ev_addr[k][ev_n[k]] = a;
        ev_tag[k][ev_n[k]]  = tag;
        ev_n[k]++;
    endtask

    // Schedule from R2..R7 and R9: times in cycles after reset release.
    task automatic build(input int k, input int stable, input int ckew, input int tmrd,
                         input int trp, input int trfc, input int nref, input int dllw,
                         input logic [13:0] mrb, input logic [13:0] e1b,
                         input logic [13:0] e2, input logic [13:0] e3);
        int t;
        int t_mr;
        logic [13:0] e1n;
        e1n = e1b & ~14'h0381;
        ev_n[k] = 0;
        ev_ptr[k] = 0;
        t_cke[k] = stable;                                  // R2
        t = stable + ckew;
        push(k, t, 4'b0010, 3'd0, 14'h0400, 3);  t += trp;   // R3
        push(k, t, 4'b0000, 3'd2, e2, 4);        t += tmrd;
        push(k, t, 4'b0000, 3'd3, e3, 4);        t += tmrd;
        push(k, t, 4'b0000, 3'd1, e1n, 4);       t += tmrd;
        t_mr = t;
        push(k, t, 4'b0000, 3'd0, mrb | 14'h0100, 4); t += tmrd;
        push(k, t, 4'b0010, 3'd0, 14'h0400, 4);  t += trp;
        for (int i = 0; i < nref; i++) begin
            push(k, t, 4'b0001, 3'd0, 14'h0000, 5); t += trfc;   // R5
        end
        push(k, t, 4'b0000, 3'd0, mrb & ~14'h0100, 4); t += tmrd;
        if (t_mr + dllw > t) t = t_mr + dllw;                 // R6
        push(k, t, 4'b0000, 3'd1, e1n | 14'h0380, 6); t += tmrd;
        push(k, t, 4'b0000, 3'd1, e1n, 4);       t += tmrd;
        t_done[k] = t;                                        // R9
    endtask

    task automatic compare(input int k, input int cyc, input logic c_cke, input logic c_odt,
                           input logic [3:0] pins, input logic [2:0] b, input logic [13:0] a,
                           input logic c_done);
        logic [3:0]  e_pins;
        logic [2:0]  e_ba;
        logic [13:0] e_addr;
        int          tag;
        e_pins = 4'b0111; e_ba = '0; e_addr = '0; tag = 8;   // R8 idle bus
        if (ev_ptr[k] < ev_n[k] && ev_t[k][ev_ptr[k]] == cyc) begin
            e_pins = ev_pins[k][ev_ptr[k]];
            e_ba   = ev_ba[k][ev_ptr[k]];
            e_addr = ev_addr[k][ev_ptr[k]];
            tag    = ev_tag[k][ev_ptr[k]];
            ev_ptr[k]++;
        end
        check(c_cke == (cyc >= t_cke[k]), (cyc >= t_cke[k]) ? 10 : 2, k, cyc, 32'(c_cke),
              32'(cyc >= t_cke[k]));                           // R2, R10
        check(c_odt == 1'b0, 8, k, cyc, 32'(c_odt), 0);       // R8
        check(pins == e_pins, tag, k, cyc, 32'(pins), 32'(e_pins));
        check({b, a} == {e_ba, e_addr}, (tag == 8) ? 8 : 7, k, cyc,
              32'({b, a}), 32'({e_ba, e_addr}));              // R7
        check(c_done == (cyc >= t_done[k]), 9, k, cyc, 32'(c_done), 32'(cyc >= t_done[k]));
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int last;
        build(0, 40000, 80, 2, 3, 26, 2, 200, 14'h0A62, 14'h0004, 14'h0000, 14'h0000);
        build(1, 50, 10, 3, 4, 30, 3, 40, 14'h0D53, 14'h0387, 14'h0080, 14'h0001);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check({cke0, odt0, cs0, ras0, cas0, we0, ba0, addr0, done0} ==
              {1'b0, 1'b0, 4'b0111, 3'd0, 14'd0, 1'b0}, 1, 0, 0, 32'({cs0, ras0, cas0, we0}), 32'h7);
        check({cke1, odt1, cs1, ras1, cas1, we1, ba1, addr1, done1} ==
              {1'b0, 1'b0, 4'b0111, 3'd0, 14'd0, 1'b0}, 1, 1, 0, 32'({cs1, ras1, cas1, we1}), 32'h7);
        rst_n = 1'b1;
        last = t_done[0] + 20;
        for (int cyc = 1; cyc <= last; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            compare(0, cyc, cke0, odt0, {cs0, ras0, cas0, we0}, ba0, addr0, done0);
            compare(1, cyc, cke1, odt1, {cs1, ras1, cas1, we1}, ba1, addr1, done1);
        end
        // Every scheduled command was observed (R4).
        check(ev_ptr[0] == ev_n[0], 4, 0, last, 32'(ev_ptr[0]), 32'(ev_n[0]));
        check(ev_ptr[1] == ev_n[1], 4, 1, last, 32'(ev_ptr[1]), 32'(ev_n[1]));
        finish_run();
    end

endmodule